// File: doc/BRIEF.md
# Sector Address Advance Unit

This unit keeps the cylinder, head, sector and size values of a running multi-sector read and moves them forward each time a sector finishes. A load strobe takes the starting address, the final sector number of the track and the multi-track flag from the command. After that, every sector-done strobe does one of three things. It steps the sector number. It turns the read over to the other side of the same cylinder. Or it ends the pass: the cylinder moves on and the sector number goes back to one.

The registered address is also the value reported once the command completes. A preview of the address the next strobe would produce is always available on separate outputs. The unit raises a sticky stop flag when the pass is over. It pulses a side-switch flag for one cycle when a multi-track read goes on to side 1.

Top module: `sadv_top`

## Requirements
- R1: While reset is low, and after it is released until the first load, the cylinder, head, sector and size outputs are zero, and the stop and side-switch outputs are low.
- R2: A load strobe writes the four address inputs into the address registers on the next clock edge. It also captures the final sector number and the multi-track flag, and clears the stop flag. A load takes precedence over a done strobe in the same cycle.
- R3: When a done strobe arrives and the sector number is below the final sector, the sector number increases by one. Cylinder, head and size stay the same, and stop stays low.
- R4: With the multi-track flag clear, a done strobe at the final sector increases the cylinder by one and sets the sector to 1. Head and size are unchanged, and stop is raised.
- R5: With the multi-track flag set and head bit 0 equal to 0, a done strobe at the final sector complements head bit 0 and sets the sector to 1. Cylinder and size are unchanged, stop stays low, and the side-switch output is high for exactly the following cycle.
- R6: With the multi-track flag set and head bit 0 equal to 1, a done strobe at the final sector increases the cylinder by one, complements head bit 0 and sets the sector to 1. Size is unchanged and stop is raised. A multi-track pass that starts at sector 1 of side 0 therefore ends after twice the sectors per track.
- R7: In a cycle with neither a load nor an accepted done strobe, all address outputs hold their values.
- R8: Once stop is high, done strobes have no effect on any output until the next load.
- R9: A sector number above the final sector is handled exactly like one equal to it.
- R10: The preview outputs always equal the cylinder, head and sector that the next done strobe would store.
- R11: The final sector number and the multi-track flag are used as captured at load. Changes on those inputs after the load have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Start of command: capture the address inputs |
| ld_cyl_i | input | C_W | Starting cylinder |
| ld_head_i | input | H_W | Starting head; bit 0 is the side |
| ld_sec_i | input | R_W | Starting sector number |
| ld_size_i | input | N_W | Sector size code |
| ld_eot_i | input | R_W | Final sector number of the track |
| ld_mt_i | input | 1 | Multi-track flag, 1 = continue onto side 1 |
| done_i | input | 1 | One sector finished |
| cyl_o | output | C_W | Current / result cylinder |
| head_o | output | H_W | Current / result head |
| sec_o | output | R_W | Current / result sector |
| size_o | output | N_W | Current / result size code |
| nxt_cyl_o | output | C_W | Cylinder after the next done |
| nxt_head_o | output | H_W | Head after the next done |
| nxt_sec_o | output | R_W | Sector after the next done |
| side_sw_o | output | 1 | One-cycle pulse: the read moved to side 1 |
| stop_o | output | 1 | Pass finished (sticky until load) |

## Verification
The address is stepped through full passes under four patterns: single-track on side 0, single-track on side 1, multi-track starting on side 0, and multi-track starting on side 1. Those four separate the three end-of-track outcomes. They also confirm the doubled sector count of a full multi-track pass. Further cases cover a start sector beyond the final sector, head values whose upper bits are set, and done strobes given after stop. Changes on the flag and final-sector inputs after a load must be ignored. A behavioural model tracks every output, the previews included, on every cycle.

// File: rtl/sadv_pkg.sv
package sadv_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_SEC  = 2'd1,
    STEP_SIDE = 2'd2,
    STEP_CYL  = 2'd3
  } step_e;
endpackage

// File: rtl/sadv_decide.sv
module sadv_decide
  import sadv_pkg::*;
#(
  parameter int C_W = 8,
  parameter int H_W = 8,
  parameter int R_W = 8
) (
  input  logic [C_W-1:0] cur_c,
  input  logic [H_W-1:0] cur_h,
  input  logic [R_W-1:0] cur_r,
  input  logic [R_W-1:0] eot,
  input  logic           mt,
  output step_e          step,
  output logic           at_end,
  output logic           ends_pass,
  output logic [C_W-1:0] nxt_c,
  output logic [H_W-1:0] nxt_h,
  output logic [R_W-1:0] nxt_r
);
  // sector step inside the track
  function automatic logic [R_W-1:0] f_sec_inc(input logic [R_W-1:0] r);
    return r + R_W'(1);
  endfunction

  // other side of the same cylinder: only bit 0 of the head moves
  function automatic logic [H_W-1:0] f_side_flip(input logic [H_W-1:0] h);
    return h ^ H_W'(1);
  endfunction

  function automatic logic [C_W-1:0] f_cyl_inc(input logic [C_W-1:0] c);
    return c + C_W'(1);
  endfunction

  // an overshoot counts as the end of the track
  function automatic logic f_track_end(input logic [R_W-1:0] r, input logic [R_W-1:0] e);
    return r >= e;
  endfunction

  logic side_q;
  assign side_q = cur_h[0];
  assign at_end = f_track_end(cur_r, eot);

  always_comb begin
    if (!at_end)            step = STEP_SEC;
    else if (mt && !side_q) step = STEP_SIDE;
    else                    step = STEP_CYL;
  end

  assign ends_pass = (step == STEP_CYL);

  always_comb begin
    nxt_c = cur_c;
    nxt_h = cur_h;
    nxt_r = f_sec_inc(cur_r);
    unique case (step)
      STEP_SIDE: begin
        nxt_h = f_side_flip(cur_h);
        nxt_r = R_W'(1);
      end
      STEP_CYL: begin
        nxt_c = f_cyl_inc(cur_c);
        if (mt) nxt_h = f_side_flip(cur_h);
        nxt_r = R_W'(1);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sadv_regs.sv
module sadv_regs #(
  parameter int C_W = 8,
  parameter int H_W = 8,
  parameter int R_W = 8,
  parameter int N_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [C_W-1:0] ld_c,
  input  logic [H_W-1:0] ld_h,
  input  logic [R_W-1:0] ld_r,
  input  logic [N_W-1:0] ld_n,
  input  logic [R_W-1:0] ld_eot,
  input  logic           ld_mt,
  input  logic           fire,
  input  logic           to_side,
  input  logic           ends_pass,
  input  logic [C_W-1:0] nxt_c,
  input  logic [H_W-1:0] nxt_h,
  input  logic [R_W-1:0] nxt_r,
  output logic [C_W-1:0] c_q,
  output logic [H_W-1:0] h_q,
  output logic [R_W-1:0] r_q,
  output logic [N_W-1:0] n_q,
  output logic [R_W-1:0] eot_q,
  output logic           mt_q,
  output logic           stop_q,
  output logic           sw_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_q    <= '0;
      h_q    <= '0;
      r_q    <= '0;
      n_q    <= '0;
      eot_q  <= '0;
      mt_q   <= 1'b0;
      stop_q <= 1'b0;
      sw_q   <= 1'b0;
    end else if (load) begin
      c_q    <= ld_c;
      h_q    <= ld_h;
      r_q    <= ld_r;
      n_q    <= ld_n;
      eot_q  <= ld_eot;
      mt_q   <= ld_mt;
      stop_q <= 1'b0;
      sw_q   <= 1'b0;
    end else if (fire) begin
      c_q    <= nxt_c;
      h_q    <= nxt_h;
      r_q    <= nxt_r;
      stop_q <= ends_pass;
      sw_q   <= to_side;
    end else begin
      sw_q   <= 1'b0;
    end
  end
endmodule

// File: rtl/sadv_top.sv
module sadv_top
  import sadv_pkg::*;
#(
  parameter int C_W = 8,
  parameter int H_W = 8,
  parameter int R_W = 8,
  parameter int N_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic [C_W-1:0] ld_cyl_i,
  input  logic [H_W-1:0] ld_head_i,
  input  logic [R_W-1:0] ld_sec_i,
  input  logic [N_W-1:0] ld_size_i,
  input  logic [R_W-1:0] ld_eot_i,
  input  logic           ld_mt_i,
  input  logic           done_i,
  output logic [C_W-1:0] cyl_o,
  output logic [H_W-1:0] head_o,
  output logic [R_W-1:0] sec_o,
  output logic [N_W-1:0] size_o,
  output logic [C_W-1:0] nxt_cyl_o,
  output logic [H_W-1:0] nxt_head_o,
  output logic [R_W-1:0] nxt_sec_o,
  output logic           side_sw_o,
  output logic           stop_o
);
  logic [C_W-1:0] c_q, nxt_c;
  logic [H_W-1:0] h_q, nxt_h;
  logic [R_W-1:0] r_q, nxt_r, eot_q;
  logic [N_W-1:0] n_q;
  logic           mt_q, stop_q, sw_q;
  step_e          step;
  logic           at_end, ends_pass, to_side;
  logic           adv_fire;

  // an accepted sector-done event
  assign adv_fire = done_i && !stop_q && !load_i;
  assign to_side  = (step == STEP_SIDE);

  sadv_decide #(.C_W(C_W), .H_W(H_W), .R_W(R_W)) u_decide (
    .cur_c(c_q), .cur_h(h_q), .cur_r(r_q), .eot(eot_q), .mt(mt_q),
    .step(step), .at_end(at_end), .ends_pass(ends_pass),
    .nxt_c(nxt_c), .nxt_h(nxt_h), .nxt_r(nxt_r)
  );

  sadv_regs #(.C_W(C_W), .H_W(H_W), .R_W(R_W), .N_W(N_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .load(load_i),
    .ld_c(ld_cyl_i), .ld_h(ld_head_i), .ld_r(ld_sec_i), .ld_n(ld_size_i),
    .ld_eot(ld_eot_i), .ld_mt(ld_mt_i),
    .fire(adv_fire), .to_side(to_side), .ends_pass(ends_pass),
    .nxt_c(nxt_c), .nxt_h(nxt_h), .nxt_r(nxt_r),
    .c_q(c_q), .h_q(h_q), .r_q(r_q), .n_q(n_q),
    .eot_q(eot_q), .mt_q(mt_q), .stop_q(stop_q), .sw_q(sw_q)
  );

  assign cyl_o      = c_q;
  assign head_o     = h_q;
  assign sec_o      = r_q;
  assign size_o     = n_q;
  assign nxt_cyl_o  = nxt_c;
  assign nxt_head_o = nxt_h;
  assign nxt_sec_o  = nxt_r;
  assign side_sw_o  = sw_q;
  assign stop_o     = stop_q;
endmodule

// File: rtl/sadv_chk.sv
module sadv_chk #(
  parameter int C_W = 8,
  parameter int H_W = 8,
  parameter int R_W = 8,
  parameter int N_W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           load_i,
  input logic [R_W-1:0] ld_sec_i,
  input logic           adv_fire,
  input logic           at_end,
  input logic [C_W-1:0] cyl_o,
  input logic [H_W-1:0] head_o,
  input logic [R_W-1:0] sec_o,
  input logic [N_W-1:0] size_o,
  input logic [C_W-1:0] nxt_cyl_o,
  input logic [H_W-1:0] nxt_head_o,
  input logic [R_W-1:0] nxt_sec_o,
  input logic           side_sw_o,
  input logic           stop_o
);
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (sec_o == $past(ld_sec_i) && !stop_o)); // R2
  AST_MID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_fire && !at_end) |=> (sec_o == $past(sec_o) + R_W'(1) && !stop_o && $stable(cyl_o))); // R3
  AST_END_SEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_fire && at_end) |=> (sec_o == R_W'(1))); // R4
  AST_SIDE_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    side_sw_o |-> (!stop_o && sec_o == R_W'(1))); // R5
  AST_CYL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv_fire |=> (cyl_o == $past(cyl_o) || cyl_o == $past(cyl_o) + C_W'(1))); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_fire) |=> ($stable(cyl_o) && $stable(head_o) && $stable(sec_o) && $stable(size_o))); // R7
  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_o && !load_i) |=> (stop_o && $stable(sec_o) && !side_sw_o)); // R8
  AST_PREVIEW_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    adv_fire |=> (sec_o == $past(nxt_sec_o) && cyl_o == $past(nxt_cyl_o) && head_o == $past(nxt_head_o))); // R10
endmodule

bind sadv_top sadv_chk #(.C_W(C_W), .H_W(H_W), .R_W(R_W), .N_W(N_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_i(load_i), .ld_sec_i(ld_sec_i),
  .adv_fire(adv_fire), .at_end(at_end),
  .cyl_o(cyl_o), .head_o(head_o), .sec_o(sec_o), .size_o(size_o),
  .nxt_cyl_o(nxt_cyl_o), .nxt_head_o(nxt_head_o), .nxt_sec_o(nxt_sec_o),
  .side_sw_o(side_sw_o), .stop_o(stop_o)
);

// File: tb/tb_sadv_top.sv
`timescale 1ns/1ps
module tb_sadv_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       load_i = 1'b0, ld_mt_i = 1'b0, done_i = 1'b0;
  logic [7:0] ld_cyl_i = '0, ld_head_i = '0, ld_sec_i = '0, ld_size_i = '0, ld_eot_i = '0;
  logic [7:0] cyl_o, head_o, sec_o, size_o, nxt_cyl_o, nxt_head_o, nxt_sec_o;
  logic       side_sw_o, stop_o;

  sadv_top dut (.*);

  int n_run = 0, n_fail = 0;
  string cur_req = "R1";
  bit model_on = 0;

  // behavioural reference
  int mc = 0, mh = 0, mr = 0, mn = 0, meot = 0, mmt = 0, mstop = 0, msw = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      mc <= 0; mh <= 0; mr <= 0; mn <= 0; meot <= 0; mmt <= 0; mstop <= 0; msw <= 0;
    end else if (load_i) begin
      mc <= ld_cyl_i; mh <= ld_head_i; mr <= ld_sec_i; mn <= ld_size_i;
      meot <= ld_eot_i; mmt <= ld_mt_i; mstop <= 0; msw <= 0;
    end else if (done_i && mstop == 0) begin
      if (mr < meot) begin mr <= (mr + 1) % 256; msw <= 0; end
      else if (mmt != 0 && mh % 2 == 0) begin mh <= mh + 1; mr <= 1; msw <= 1; end
      else begin
        mc <= (mc + 1) % 256; mr <= 1; mstop <= 1; msw <= 0;
        if (mmt != 0) mh <= mh - 1;
      end
    end else msw <= 0;
  end

  function automatic int exp_nc(); return (mr >= meot && !(mmt != 0 && mh % 2 == 0)) ? (mc + 1) % 256 : mc; endfunction
  function automatic int exp_nh(); return (mr >= meot && mmt != 0) ? (mh ^ 1) : mh; endfunction
  function automatic int exp_nr(); return (mr >= meot) ? 1 : (mr + 1) % 256; endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // every-cycle comparison, away from the active edge
  always @(negedge clk) if (model_on) begin
    n_run++;
    if (int'(cyl_o) != mc || int'(head_o) != mh || int'(sec_o) != mr || int'(size_o) != mn ||
        int'(stop_o) != mstop || int'(side_sw_o) != msw) begin
      n_fail++;
      $display("FAIL %s model C/H/R/N/stop/sw actual=%0d/%0d/%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d/%0d/%0d",
               cur_req, cyl_o, head_o, sec_o, size_o, stop_o, side_sw_o, mc, mh, mr, mn, mstop, msw);
    end
    n_run++;
    if (int'(nxt_cyl_o) != exp_nc() || int'(nxt_head_o) != exp_nh() || int'(nxt_sec_o) != exp_nr()) begin
      n_fail++;
      $display("FAIL R10 preview actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
               nxt_cyl_o, nxt_head_o, nxt_sec_o, exp_nc(), exp_nh(), exp_nr());
    end
  end

  task automatic do_load(int c, int h, int r, int n, int eot, int mt);
    @(negedge clk);
    load_i = 1; ld_cyl_i = 8'(c); ld_head_i = 8'(h); ld_sec_i = 8'(r);
    ld_size_i = 8'(n); ld_eot_i = 8'(eot); ld_mt_i = mt[0];
    @(negedge clk);
    load_i = 0;
  endtask

  // one done per cycle until stop or limit; returns strobes accepted
  task automatic run_pass(int limit, output int cnt);
    cnt = 0;
    while (!stop_o && cnt < limit) begin
      @(negedge clk); done_i = 1; cnt++;
      @(negedge clk); done_i = 0;
    end
  endtask

  task automatic one_done();
    @(negedge clk); done_i = 1;
    @(negedge clk); done_i = 0;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    chk("R1", "sec in reset", int'(sec_o), 0);
    chk("R1", "stop in reset", int'(stop_o), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "cyl after reset", int'(cyl_o), 0);
    chk("R1", "side_sw after reset", int'(side_sw_o), 0);
    model_on = 1;

    cur_req = "R2";
    do_load(5, 0, 25, 1, 26, 1);
    chk("R2", "loaded cyl", int'(cyl_o), 5);
    chk("R2", "loaded sec", int'(sec_o), 25);
    chk("R2", "loaded size", int'(size_o), 1);

    cur_req = "R3";
    one_done();
    chk("R3", "sec step", int'(sec_o), 26);
    chk("R3", "head unchanged", int'(head_o), 0);
    repeat (4) @(negedge clk);
    chk("R7", "idle hold sec", int'(sec_o), 26);

    cur_req = "R5";
    @(negedge clk); done_i = 1;
    @(negedge clk); done_i = 0;
    chk("R5", "side switch pulse", int'(side_sw_o), 1);
    chk("R5", "head bit0 flipped", int'(head_o), 1);
    chk("R5", "cyl unchanged", int'(cyl_o), 5);
    chk("R5", "stop low", int'(stop_o), 0);
    @(negedge clk);
    chk("R5", "pulse one cycle", int'(side_sw_o), 0);

    cur_req = "R6";
    run_pass(100, cnt);
    chk("R6", "strobes on side 1", cnt, 26);
    chk("R6", "cyl stepped", int'(cyl_o), 6);
    chk("R6", "head back to 0", int'(head_o), 0);
    chk("R6", "sec one", int'(sec_o), 1);
    chk("R6", "stop high", int'(stop_o), 1);

    cur_req = "R8";
    repeat (3) one_done();
    chk("R8", "cyl frozen", int'(cyl_o), 6);
    chk("R8", "sec frozen", int'(sec_o), 1);

    cur_req = "R6";
    do_load(0, 0, 1, 0, 26, 1);
    run_pass(200, cnt);
    chk("R6", "full multi-track pass length", cnt, 52);

    cur_req = "R4";
    do_load(10, 1, 1, 2, 8, 0);
    run_pass(100, cnt);
    chk("R4", "single-track pass length", cnt, 8);
    chk("R4", "cyl stepped", int'(cyl_o), 11);
    chk("R4", "head unchanged side 1", int'(head_o), 1);
    chk("R4", "sec one", int'(sec_o), 1);
    chk("R4", "stop", int'(stop_o), 1);

    cur_req = "R9";
    do_load(3, 0, 12, 0, 8, 0);
    one_done();
    chk("R9", "overshoot ends", int'(stop_o), 1);
    chk("R9", "cyl stepped", int'(cyl_o), 4);

    cur_req = "R6";
    do_load(7, 8'h83, 9, 3, 9, 1);
    one_done();
    chk("R6", "upper head bits kept", int'(head_o), 8'h82);
    chk("R6", "cyl", int'(cyl_o), 8);

    cur_req = "R11";
    do_load(2, 8'h02, 5, 0, 5, 1);
    ld_mt_i = 0; ld_eot_i = 3;
    one_done();
    chk("R11", "captured mt used", int'(stop_o), 0);
    chk("R11", "head flipped", int'(head_o), 3);
    one_done();
    chk("R11", "captured eot used", int'(sec_o), 2);

    cur_req = "R2";
    @(negedge clk);
    load_i = 1; done_i = 1; ld_cyl_i = 40; ld_head_i = 0; ld_sec_i = 4; ld_size_i = 2; ld_eot_i = 9; ld_mt_i = 0;
    @(negedge clk);
    load_i = 0; done_i = 0;
    chk("R2", "load beats done", int'(sec_o), 4);

    repeat (2) @(negedge clk);
    model_on = 0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule